// File: doc/BRIEF.md
# SPI Master Transfer Engine with Programmable Bit Clock

This block runs one full-duplex SPI transfer as a bus master from a single system clock. A start pulse latches a parallel transmit word and a divider value. The block then pulls its active-low select line down and produces a serial clock whose period and duty cycle come from the divider. It shifts the word out most significant bit first and shifts the input line into a receive register. When the frame closes, it releases select, stops driving its data output, and pulses a done flag. The received word is valid in the same cycle as that flag.

The frame is a clock-stop frame. The serial clock rests low between transfers. The first rising edge comes one clock-low time after select falls, and it presents the first data bit. Each later bit changes on a rising edge, and input bits are taken at falling edges. One extra rising edge ends the last bit. At that edge the data output turns off, and select returns high one clock-high time later. For even divider values the high phase is one system cycle longer than the low phase.

Top module: `spi_mst_engine`

## Requirements
- R1: While reset is asserted and on leaving reset, the outputs are: ss_n=1, sclk=0, mosi=0, mosi_oe=0, busy=0, done=0, rx_word=0.
- R2: With d = max(div,1), L = floor((d+1)/2) and H = d+1-L, a start accepted at a clock edge drives ss_n low in the next cycle t0. Every serial clock period is d+1 system cycles. Rising edges fall at t0+L+k(d+1) for k = 0..N, where N is the word length, and falling edges come H cycles after each rising edge.
- R3: For odd d the high and low phases are equal (both (d+1)/2). For even d the high phase is d/2+1 cycles and the low phase is d/2 cycles.
- R4: A divider value of 0 produces exactly the same frame as a divider value of 1.
- R5: Bit N-1-k of the transmit word is on mosi with mosi_oe=1 from rising edge k for d+1 cycles (k = 0..N-1), so the most significant bit goes first.
- R6: The level on miso in the last system cycle of high phase k (k = 0..N-1) becomes bit N-1-k of the received word.
- R7: At rising edge N, mosi_oe and mosi go to 0. ss_n returns high, and sclk goes low, H cycles later, at t0+(N+1)(d+1). sclk stays low while ss_n is high.
- R8: done is high for exactly the one cycle in which ss_n rises, and rx_word holds the received word from that cycle on. busy is high exactly while ss_n is low.
- R9: A start pulse while busy is ignored. The frame in progress, its transmit data and its timing are unchanged, and no second frame follows.
- R10: The divider and transmit word are sampled only when a start is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request pulse |
| tx_word | input | WIDTH | Word to transmit |
| div | input | DIV_W | Divider value setting the serial clock period |
| miso | input | 1 | Serial data input |
| sclk | output | 1 | Serial clock, idles low |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data output |
| mosi_oe | output | 1 | Output enable for mosi (0 means high impedance) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | WIDTH | Received word |

## Verification
The bench compares every output on every cycle of each frame against a cycle model derived from L and H. It covers odd, even, zero and minimum dividers, so a design with a balanced duty cycle for even values shows a wrong high phase, and one that mishandles a zero divider produces a runaway or collapsed clock. A slave model changes miso only at rising edges. A design that samples on the wrong edge, or shifts the wrong way, therefore returns a rotated or reversed word. A start pulse and a new divider and transmit word are injected mid-frame, which exposes a design that restarts or retimes itself. The tail of each frame is checked for the extra rising edge, the early turn-off of the output enable, and the late release of select, so an off-by-one frame length is detected.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2
  } phase_e;
endpackage

// File: rtl/spi_mst_phase.sv
// Derives low/high phase lengths (system cycles) from the divider value.
module spi_mst_phase #(
  parameter int DIV_W = 8
) (
  input  logic [DIV_W-1:0] div,
  output logic [DIV_W-1:0] lo_len,
  output logic [DIV_W-1:0] hi_len
);
  logic [DIV_W-1:0] d_eff;
  logic [DIV_W:0]   period;
  logic [DIV_W:0]   lo_w;
  logic [DIV_W:0]   hi_w;

  always_comb begin
    d_eff  = (div == '0) ? DIV_W'(1) : div;
    period = {1'b0, d_eff} + (DIV_W+1)'(1);
    lo_w   = period >> 1;
    hi_w   = period - lo_w;
    lo_len = lo_w[DIV_W-1:0];
    hi_len = hi_w[DIV_W-1:0];
  end
endmodule

// File: rtl/spi_mst_txsr.sv
// Transmit shift register, MSB presented first.
module spi_mst_txsr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic [WIDTH-1:0] din,
  output logic             msb
);
  logic [WIDTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= din;
    else if (shift) sr <= {sr[WIDTH-2:0], 1'b0};
  end

  assign msb = sr[WIDTH-1];
endmodule

// File: rtl/spi_mst_rxsr.sv
// Receive shift register, first bit lands in the MSB after WIDTH shifts.
module spi_mst_rxsr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             shift,
  input  logic             din,
  output logic [WIDTH-1:0] word
);
  always_ff @(posedge clk) begin
    if (rst)        word <= '0;
    else if (clr)   word <= '0;
    else if (shift) word <= {word[WIDTH-2:0], din};
  end
endmodule

// File: rtl/spi_mst_engine.sv
module spi_mst_engine
  import spi_mst_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] tx_word,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             sclk,
  output logic             ss_n,
  output logic             mosi,
  output logic             mosi_oe,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] rx_word
);
  localparam int CNT_W = $clog2(WIDTH + 2);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(WIDTH);
  localparam logic [CNT_W-1:0] END_EDGE  = CNT_W'(WIDTH + 1);

  phase_e           state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lo_q, hi_q;
  logic [DIV_W-1:0] lo_len, hi_len;
  logic [CNT_W-1:0] edge_cnt;
  logic             tx_msb;
  logic [WIDTH-1:0] rx_sr;

  logic accept, rise_now, fall_now, tx_shift, rx_shift;

  always_comb begin
    accept   = (state == ST_IDLE) && start;
    rise_now = (state == ST_LO) && (cnt == '0);
    fall_now = (state == ST_HI) && (cnt == '0);
    tx_shift = rise_now && (edge_cnt < LAST_DATA);
    rx_shift = fall_now && (edge_cnt != END_EDGE);
  end

  spi_mst_phase #(.DIV_W(DIV_W)) u_phase (
    .div    (div),
    .lo_len (lo_len),
    .hi_len (hi_len)
  );

  spi_mst_txsr #(.WIDTH(WIDTH)) u_txsr (
    .clk   (clk),
    .rst   (rst),
    .load  (accept),
    .shift (tx_shift),
    .din   (tx_word),
    .msb   (tx_msb)
  );

  spi_mst_rxsr #(.WIDTH(WIDTH)) u_rxsr (
    .clk   (clk),
    .rst   (rst),
    .clr   (accept),
    .shift (rx_shift),
    .din   (miso),
    .word  (rx_sr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      edge_cnt <= '0;
      sclk     <= 1'b0;
      ss_n     <= 1'b1;
      mosi     <= 1'b0;
      mosi_oe  <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      rx_word  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_LO;
            ss_n     <= 1'b0;
            busy     <= 1'b1;
            lo_q     <= lo_len;
            hi_q     <= hi_len;
            cnt      <= lo_len - DIV_W'(1);
            edge_cnt <= '0;
          end
        end
        ST_LO: begin
          if (cnt == '0) begin
            state    <= ST_HI;
            sclk     <= 1'b1;
            cnt      <= hi_q - DIV_W'(1);
            edge_cnt <= edge_cnt + CNT_W'(1);
            if (edge_cnt < LAST_DATA) begin
              mosi    <= tx_msb;
              mosi_oe <= 1'b1;
            end else begin
              mosi    <= 1'b0;
              mosi_oe <= 1'b0;
            end
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        ST_HI: begin
          if (cnt == '0) begin
            sclk <= 1'b0;
            if (edge_cnt == END_EDGE) begin
              state   <= ST_IDLE;
              ss_n    <= 1'b1;
              busy    <= 1'b0;
              done    <= 1'b1;
              rx_word <= rx_sr;
            end else begin
              state <= ST_LO;
              cnt   <= lo_q - DIV_W'(1);
            end
          end else begin
            cnt <= cnt - DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_mst_engine_chk.sv
module spi_mst_engine_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sclk,
  input logic             ss_n,
  input logic             mosi,
  input logic             mosi_oe,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] rx_word
);
  p_oe_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
    mosi_oe |-> !ss_n);

  p_idle_mosi_low_r7: assert property (@(posedge clk) disable iff (rst)
    !mosi_oe |-> !mosi);

  p_idle_sclk_low_r7: assert property (@(posedge clk) disable iff (rst)
    ss_n |-> !sclk);

  p_busy_tracks_ss_r8: assert property (@(posedge clk) disable iff (rst)
    busy == !ss_n);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_release_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_n) |-> done);

  p_done_needs_release_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> ss_n);

  p_rx_changes_on_done_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word) |-> done);

  p_lead_low_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(ss_n) |-> !sclk);
endmodule

bind spi_mst_engine spi_mst_engine_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sclk    (sclk),
  .ss_n    (ss_n),
  .mosi    (mosi),
  .mosi_oe (mosi_oe),
  .busy    (busy),
  .done    (done),
  .rx_word (rx_word)
);

// File: tb/spi_mst_engine_tb.sv
`timescale 1ns/1ps
module spi_mst_engine_tb;
  localparam int N  = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [N-1:0]  tx_word = '0;
  logic [DW-1:0] div = '0;
  logic          miso = 1'b0;
  logic          sclk, ss_n, mosi, mosi_oe, busy, done;
  logic [N-1:0]  rx_word;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  spi_mst_engine #(.WIDTH(N), .DIV_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .tx_word(tx_word), .div(div),
    .miso(miso), .sclk(sclk), .ss_n(ss_n), .mosi(mosi), .mosi_oe(mosi_oe),
    .busy(busy), .done(done), .rx_word(rx_word)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(ss_n == 1'b1 && sclk == 1'b0 && mosi_oe == 1'b0 && mosi == 1'b0,
        "R1 lines in reset", {ss_n, sclk, mosi_oe, mosi}, 4'b1000);
    chk(busy == 1'b0 && done == 1'b0 && rx_word == '0,
        "R1 status in reset", {busy, done, rx_word}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ss_n == 1'b1 && sclk == 1'b0 && busy == 1'b0,
        "R1 after reset", {ss_n, sclk, busy}, 3'b100);
  endtask

  // One frame, checked every cycle against the timing model of R2..R8.
  // glitch: inject a start pulse and new div/tx mid-frame (R9, R10).
  task automatic t_frame(input logic [N-1:0] tx, input int d_in,
                         input logic [N-1:0] sw, input bit glitch, input string name);
    int d, lo, hi, per, fend;
    d    = (d_in == 0) ? 1 : d_in;
    lo   = (d + 1) / 2;
    hi   = d + 1 - lo;
    per  = d + 1;
    fend = (N + 1) * per;
    @(negedge clk);
    tx_word = tx;
    div     = DW'(d_in);
    start   = 1'b1;
    for (int c = 0; c <= fend + 3; c++) begin
      int k, r;
      bit e_sclk, e_ssn, e_oe, e_mosi, e_done;
      @(negedge clk);
      if (c == 0) start = 1'b0;
      if (glitch && c == 3) begin
        start = 1'b1; div = DW'(d_in + 3); tx_word = ~tx;
      end
      if (glitch && c == 4) start = 1'b0;
      if (c >= fend && glitch && c == fend) start = 1'b0;
      k = (c >= lo) ? (c - lo) / per : -1;
      r = (c >= lo) ? (c - lo) % per : 0;
      e_ssn  = (c >= fend);
      e_sclk = !e_ssn && (k >= 0) && (r < hi);
      e_oe   = !e_ssn && (k >= 0) && (k < N);
      e_mosi = e_oe ? tx[N-1-k] : 1'b0;
      e_done = (c == fend);
      chk(sclk == e_sclk, {"R2/R3 sclk ", name}, sclk, e_sclk);
      chk(ss_n == e_ssn, {"R7 ss_n ", name}, ss_n, e_ssn);
      chk(mosi_oe == e_oe, {"R5/R7 mosi_oe ", name}, mosi_oe, e_oe);
      chk(mosi == e_mosi, {"R5 mosi ", name}, mosi, e_mosi);
      chk(busy == !e_ssn, {"R8 busy ", name}, busy, !e_ssn);
      chk(done == e_done, {"R8/R9 done ", name}, done, e_done);
      if (c >= fend)
        chk(rx_word == sw, {"R6 rx_word ", name}, rx_word, sw);
      // slave drives its bit k for the whole of bit period k
      miso = (k >= 0 && k < N) ? sw[N-1-k] : 1'b0;
    end
    start = 1'b0;
  endtask

  initial begin
    t_reset();
    t_frame(8'hA5, 3, 8'h3C, 1'b0, "odd div3");                 // R3 equal phases
    t_frame(8'h96, 4, 8'hC1, 1'b0, "even div4");                // R3 high longer
    t_frame(8'h5A, 0, 8'h81, 1'b0, "div0 as 1");                // R4
    t_frame(8'h5A, 1, 8'h81, 1'b0, "div1");                     // R4 reference
    t_frame(8'hF0, 6, 8'h0F, 1'b1, "busy start and div change");// R9, R10
    t_frame(8'h01, 2, 8'hFE, 1'b0, "div2");                     // R2
    t_frame(8'h80, 7, 8'h7F, 1'b1, "odd div7 glitch");          // R9, R10
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule